// File: doc/BRIEF.md
# Vector Structure Load/Store Base Writeback Unit

This unit works out the new value of the base address register after a SIMD structure load or store. It takes the 32-bit instruction word, the current base address and the value read from the offset register. It decodes the addressing mode and produces the updated base together with a write-enable. Both results are registered and qualified by a valid flag one cycle later. It handles the multiple-structure form, the single-lane form and the load-and-replicate form. When the offset field names the all-ones register, each form takes its own implied immediate increment, based on the opcode, the register count, the element size and the Q bit. The unit also flags encodings that are unallocated. The memory transfer itself happens elsewhere.

The pipeline issues one instruction per cycle on `in_valid`. The writeback stage writes `new_base` into the base register, which may be the stack pointer, only when `wb_en` is high with `out_valid`.

Top module: `vls_wb_calc`

## Requirements
- R1: `out_valid` is high in exactly the cycles after an edge at which `in_valid` was sampled high. After reset, `out_valid`, `wb_en`, `unalloc` and `new_base` are all zero.
- R2: An instruction with bit 31 set, or with bits [29:25] not equal to 5'b00110, is reported as unallocated.
- R3: When bit 23 is 0 (no writeback), `new_base` equals the base and `wb_en` is 0. If the offset field bits [20:16] are nonzero in this mode, the encoding is unallocated.
- R4: When bit 23 is 1 and the offset field is not 31, `new_base` is base plus the offset-register value and `wb_en` is 1.
- R5: For the multiple-structure form (bit 24 = 0) with offset field 31, the increment depends on the opcode in bits [15:12]. Opcodes 0 and 2 give 32, opcodes 4 and 6 give 24, opcodes 8 and 10 give 16, and opcode 7 gives 8. The increment is doubled when Q (bit 30) is 1. Any other opcode is unallocated.
- R6: A multiple-structure encoding with bit 21 set is unallocated.
- R7: For the single-lane form (bit 24 = 1, opcode 0 to 11), the increment is n × w. Here n = 2·bit13 + bit21 + 1, and w comes from bits [15:14]: 1 when they are 0, 2 when they are 1, and 4 or 8 when they are 2, as bit 10 is 0 or 1.
- R8: For the replicate form (bit 24 = 1, load bit 22 = 1), opcode 12 gives an increment of (bit21 ? 2 : 1) shifted left by size bits [11:10]. Opcode 14 gives (bit21 ? 4 : 3) shifted left by size.
- R9: With bit 24 = 1, opcodes 13 and 15 are unallocated. Opcodes 12 and 14 are also unallocated when bit 22 is 0 (store).
- R10: An unallocated instruction gives `unalloc` = 1, `wb_en` = 0 and `new_base` equal to the base.
- R11: The addition is 64-bit and wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction presented this cycle |
| insn | input | 32 | Instruction word |
| base_addr | input | 64 | Current base register value |
| rm_value | input | 64 | Offset register value |
| out_valid | output | 1 | Registered result valid |
| new_base | output | 64 | Updated base address |
| wb_en | output | 1 | Base register write enable |
| unalloc | output | 1 | Encoding is unallocated |

## Verification
The bench goes after the opcode table of the multiple-structure form. A design that swapped two entries or skipped the Q doubling would write back a base off by 8 to 32 bytes. It drives every register count and width of the single-lane form, including the 4-versus-8 split on bit 10. It covers the replicate opcodes with both counts and all sizes, where a wrong multiplier gives 3 or 4 units per step. It probes register offsets against the all-ones offset field, a wrapping addition, stores that use replicate opcodes, and a nonzero offset field without writeback. A design that mishandled these would either advance the base when it must not, or fail to flag the encoding and leave the write enabled.

// File: rtl/vls_wb_calc.sv
module vls_wb_calc #(
  parameter int ADDR_W = 64,
  parameter int IMM_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       insn,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] rm_value,
  output logic              out_valid,
  output logic [ADDR_W-1:0] new_base,
  output logic              wb_en,
  output logic              unalloc
);
  localparam logic [4:0] RM_IMM = 5'd31;

  logic       single, post, load, qbit, b21, b13;
  logic [4:0] rm_f;
  logic [3:0] opc;
  logic [1:0] esize;

  assign qbit   = insn[30];
  assign single = insn[24];
  assign post   = insn[23];
  assign load   = insn[22];
  assign b21    = insn[21];
  assign rm_f   = insn[20:16];
  assign opc    = insn[15:12];
  assign b13    = insn[13];
  assign esize  = insn[11:10];

  logic class_ok, offs_bad, form_bad, bad;
  logic [IMM_W-1:0] imm;
  logic [IMM_W-1:0] multi_amt;
  logic [2:0] nregs;
  logic [1:0] lane_sh;
  logic [2:0] rep_cnt;

  assign class_ok = ~insn[31] & (insn[29:25] == 5'b00110);
  assign offs_bad = ~post & (rm_f != 5'd0);
  assign nregs    = {1'b0, b13, b21} + 3'd1;
  assign lane_sh  = (insn[15:14] == 2'd0) ? 2'd0 :
                    (insn[15:14] == 2'd1) ? 2'd1 :
                    (insn[10] ? 2'd3 : 2'd2);
  assign rep_cnt  = opc[1] ? (b21 ? 3'd4 : 3'd3) : (b21 ? 3'd2 : 3'd1);

  always_comb begin
    multi_amt = '0;
    form_bad  = 1'b0;
    imm       = '0;
    if (!single) begin
      unique case (opc)
        4'd0, 4'd2:  multi_amt = IMM_W'(32);
        4'd4, 4'd6:  multi_amt = IMM_W'(24);
        4'd8, 4'd10: multi_amt = IMM_W'(16);
        4'd7:        multi_amt = IMM_W'(8);
        default:     form_bad  = 1'b1;
      endcase
      if (b21) form_bad = 1'b1;
      imm = qbit ? (multi_amt << 1) : multi_amt;
    end else if (opc <= 4'd11) begin
      imm = IMM_W'(nregs) << lane_sh;
    end else if (load && !opc[0]) begin
      imm = IMM_W'(rep_cnt) << esize;
    end else begin
      form_bad = 1'b1;
    end
  end

  assign bad = ~class_ok | offs_bad | form_bad;

  logic [ADDR_W-1:0] incr, sum;
  assign incr = (rm_f == RM_IMM) ? ADDR_W'(imm) : rm_value;
  assign sum  = base_addr + incr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      new_base  <= '0;
      wb_en     <= 1'b0;
      unalloc   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        unalloc  <= bad;
        wb_en    <= post & ~bad;
        new_base <= (post & ~bad) ? sum : base_addr;
      end
    end
  end

  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_nowb_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !insn[23]) |=> (!wb_en && new_base == $past(base_addr)));
  p_reg_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && insn[23] && insn[20:16] != RM_IMM) |=>
      (unalloc || new_base == $past(base_addr) + $past(rm_value)));
  p_no_wb_unalloc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && unalloc) |-> !wb_en);
  p_class_bad_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && insn[31]) |=> unalloc);
endmodule

// File: tb/vls_wb_calc_tb.sv
module vls_wb_calc_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic [31:0] insn = '0;
  logic [63:0] base_addr = '0;
  logic [63:0] rm_value = '0;
  logic        out_valid, wb_en, unalloc;
  logic [63:0] new_base;
  int checks = 0, failures = 0;
  logic        exp_ua, exp_we;
  logic [63:0] exp_nb;

  always #5 clk = ~clk;

  vls_wb_calc dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
    .base_addr(base_addr), .rm_value(rm_value), .out_valid(out_valid),
    .new_base(new_base), .wb_en(wb_en), .unalloc(unalloc));

  function automatic logic [31:0] enc(input bit q, input bit sg, input bit pst,
      input bit ld, input bit b21, input logic [4:0] rm, input logic [3:0] op,
      input logic [1:0] sz);
    return {1'b0, q, 5'b00110, sg, pst, ld, b21, rm, op, sz, 10'h155};
  endfunction

  function automatic void model(input logic [31:0] i, input logic [63:0] b,
      input logic [63:0] r, output logic ua, output logic we, output logic [63:0] nb);
    int amt, op, n, w;
    bit bad;
    bad = 0; amt = 0; op = int'(i[15:12]);
    if (i[31] || i[29:25] != 5'b00110) bad = 1;
    if (!i[23] && i[20:16] != 0) bad = 1;
    if (!i[24]) begin
      if (i[21]) bad = 1;
      if (op == 0 || op == 2) amt = 32;
      else if (op == 4 || op == 6) amt = 24;
      else if (op == 8 || op == 10) amt = 16;
      else if (op == 7) amt = 8;
      else bad = 1;
      if (i[30]) amt = amt * 2;
    end else if (op <= 11) begin
      n = 2 * int'(i[13]) + int'(i[21]) + 1;
      if (i[15:14] == 0) w = 1;
      else if (i[15:14] == 1) w = 2;
      else w = i[10] ? 8 : 4;
      amt = n * w;
    end else if (i[22] && (op == 12 || op == 14)) begin
      if (op == 12) amt = i[21] ? 2 : 1;
      else amt = i[21] ? 4 : 3;
      amt = amt * (1 << int'(i[11:10]));
    end else bad = 1;
    ua = bad;
    we = !bad && i[23];
    if (we) nb = b + ((i[20:16] == 31) ? 64'(amt) : r);
    else nb = b;
  endfunction

  task automatic check(input string tag, input bit ok, input logic [63:0] act,
      input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] i, input logic [63:0] b,
      input logic [63:0] r, input bit v, input string tag);
    insn = i; base_addr = b; rm_value = r; in_valid = v;
    if (v) model(i, b, r, exp_ua, exp_we, exp_nb);
    @(negedge clk);
    check({tag, " valid R1"}, out_valid == v, 64'(out_valid), 64'(v));
    if (v) begin
      check({tag, " unalloc"}, unalloc == exp_ua, 64'(unalloc), 64'(exp_ua));
      check({tag, " wb_en"}, wb_en == exp_we, 64'(wb_en), 64'(exp_we));
      check({tag, " new_base"}, new_base == exp_nb, new_base, exp_nb);
    end
  endtask

  initial begin
    #1500000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    in_valid = 1;
    insn = enc(1, 0, 1, 1, 0, 31, 0, 0);
    base_addr = 64'h1234;
    repeat (3) @(negedge clk);
    check("R1 reset valid", out_valid == 0, 64'(out_valid), 0);
    check("R1 reset base", new_base == 0, new_base, 0);
    check("R1 reset wb", wb_en == 0 && unalloc == 0, 64'({wb_en, unalloc}), 0);
    rst_n = 1;
    in_valid = 0;
    @(negedge clk);

    step(32'h8000_0000 | enc(0, 0, 1, 1, 0, 31, 0, 0), 64'h100, 0, 1, "R2 bit31");
    step(enc(0, 0, 1, 1, 0, 31, 0, 0) ^ 32'h0200_0000, 64'h100, 0, 1, "R2 class");
    step(enc(0, 0, 0, 1, 0, 0, 7, 0), 64'h2000, 64'h55, 1, "R3 nowb");
    step(enc(0, 0, 0, 1, 0, 5, 7, 0), 64'h2000, 64'h55, 1, "R3 rm nonzero");
    step(enc(0, 1, 1, 0, 1, 4, 3, 1), 64'h3000, 64'h77, 1, "R4 reg");
    for (int op = 0; op < 16; op++)
      for (int q = 0; q < 2; q++)
        step(enc(q[0], 0, 1, op[0], 0, 31, op[3:0], 2'(op)), 64'h4000, 64'h9, 1, "R5 table");
    step(enc(1, 0, 1, 1, 1, 31, 0, 0), 64'h4000, 0, 1, "R6 b21");
    for (int k = 0; k < 64; k++) begin
      logic [31:0] i;
      i = enc(k[0], 1, 1, k[1], k[2], 31, 4'(k[5:3] * 1), 2'(k));
      i[15:14] = 2'(k[4:3] == 3 ? 2 : k[4:3]);
      i[13] = k[5];
      step(i, 64'h5000, 0, 1, "R7 lane");
    end
    for (int k = 0; k < 32; k++)
      step(enc(0, 1, 1, k[0], k[1], 31, k[2] ? 4'd14 : 4'd12, k[4:3]), 64'h6000, 0, 1,
           k[0] ? "R8 replicate" : "R9 store rep");
    step(enc(0, 1, 1, 1, 0, 31, 13, 0), 64'h6000, 0, 1, "R9 op13");
    step(enc(0, 1, 1, 1, 1, 31, 15, 0), 64'h6000, 0, 1, "R9 op15");
    step(enc(0, 0, 1, 1, 0, 31, 5, 0), 64'h7000, 0, 1, "R10 unalloc");
    step(enc(1, 0, 1, 1, 0, 31, 0, 0), 64'hFFFF_FFFF_FFFF_FFF0, 0, 1, "R11 wrap imm");
    step(enc(0, 1, 1, 0, 0, 3, 0, 0), 64'hFFFF_FFFF_FFFF_FFFF, 64'h2, 1, "R11 wrap reg");
    step(enc(0, 0, 1, 1, 0, 31, 0, 0), 64'h1, 0, 0, "R1 idle");
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] i;
      i = $urandom;
      if (k % 8 != 0) begin i[31] = 0; i[29:25] = 5'b00110; end
      if (k % 3 == 0) i[20:16] = 31;
      else if (k % 3 == 1 && !i[23]) i[20:16] = 0;
      step(i, {$urandom, $urandom}, {$urandom, $urandom}, (k % 5) != 0, "R4 R7 random");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule